// File: doc/BRIEF.md
# PTP Timestamp Snapshot Latch

This block stamps precision-time-protocol event messages with the system time, for three network channels. For each channel the MAC side raises a one-cycle pulse when an event message is transmitted or received, along with a two-bit message type. The block then decides whether that message is one it should stamp. The choice depends on the channel's master/slave mode bit. When the message qualifies, the block copies the free-running 64-bit system time into the channel's transmit or receive snapshot register.

By default a capture locks its snapshot, and a sticky flag records the lock. The lock holds until software clears the flag by writing 1 to it, so that software can read a coherent timestamp. When a channel's timestamp-all bit is set, the lock is bypassed. Every qualifying message then overwrites the snapshot and no flag is raised.

Each snapshot direction of each channel is handled by a two-state lock machine:
- `LK_OPEN`: the snapshot accepts captures.
- `LK_HELD`: the snapshot is frozen.

Transitions:
- **seize**: `LK_OPEN` to `LK_HELD` on a qualifying event while timestamp-all is clear.
- **pass**: stays in `LK_OPEN` on a qualifying event while timestamp-all is set. The event captures but does not lock.
- **release**: `LK_HELD` to `LK_OPEN` on a write-1-to-clear when no event is captured in that cycle, or when timestamp-all is set.
- **reseize**: stays in `LK_HELD` when a clear and a qualifying event arrive together while timestamp-all is clear. The event captures and the lock stays set.
- **refresh**: stays in `LK_HELD` on a qualifying event while timestamp-all is set and no clear arrives. The event captures.

Top module: `ptp_snap_latch`

## Requirements
- R1: After reset, both lock flags and both 64-bit snapshots of every channel read as 0.
- R2: Message type encoding is 0 = Sync, 1 = Delay_Req, 2 = Follow_Up and 3 = Delay_Resp. A receive event is qualifying for Delay_Req when the mode bit is 1 (master) and for Sync when the mode bit is 0 (slave). All other types never capture.
- R3: A transmit event is qualifying for Sync when the mode bit is 1 (master) and for Delay_Req when the mode bit is 0 (slave). All other types never capture.
- R4: A qualifying event that reaches an unlocked snapshot while timestamp-all is clear captures the system time present at that clock edge. It also sets the matching lock flag: bit 1 of the event register for receive, bit 0 for transmit.
- R5: While a lock flag is set and timestamp-all is clear, later qualifying events leave the matching snapshot unchanged, unless a clear arrives in the same cycle (see R7).
- R6: Writing 1 to bit 1 or bit 0 of a channel's event register clears the matching lock flag. Writing 0 to a flag bit leaves it unchanged.
- R7: When a clear and a qualifying event arrive in the same cycle while timestamp-all is clear, the snapshot takes the new time and the flag stays set.
- R8: While timestamp-all is set, every qualifying event overwrites the snapshot and does not set the lock flag.
- R9: Channel n has its event register at 0x044 + 0x20*n. Its snapshot words are at 0x048 (receive, bits 31:0), 0x04C (receive, bits 63:32), 0x050 (transmit, bits 31:0) and 0x054 (transmit, bits 63:32), each plus 0x20*n. Event-register bits 31:2 read 0 and ignore writes. Any other address reads 0.
- R10: Reading a snapshot or the event register does not change any flag or snapshot.
- R11: Events, clears and mode bits of one channel have no effect on the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | 64 | Free-running system time |
| tx_evt | input | 3 | Per-channel transmit event pulse |
| tx_type | input | 6 | Per-channel transmit message type, 2 bits each (channel n at bits 2n+1:2n) |
| rx_evt | input | 3 | Per-channel receive event pulse |
| rx_type | input | 6 | Per-channel receive message type, 2 bits each |
| mode_master | input | 3 | Per-channel mode: 1 master, 0 slave |
| ts_all | input | 3 | Per-channel timestamp-all control |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte address for read and write |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data (combinational from addr) |

## Verification
Directed cases drive each of the four message types in both modes and both directions, so that a wrong mode or direction pairing shows up as a capture that should not happen. Further directed cases cover:
- a second event against a held lock, which separates locking from overwriting;
- write-0 and reserved-bit writes against write-1 clears;
- a clear arriving in the same cycle as an event, which exposes the priority between the two;
- timestamp-all traffic.

Random traffic on all three channels, with random times, types, modes and clears, then checks channel independence and the address map against a bench model.

// File: rtl/ptp_snap_pkg.sv
package ptp_snap_pkg;

    typedef enum logic [1:0] {
        MT_SYNC    = 2'd0,
        MT_DLY_REQ = 2'd1,
        MT_FOLLOW  = 2'd2,
        MT_DLY_RSP = 2'd3
    } msg_t;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_st_t;

    // direction index: also the flag bit position in the event register
    localparam int DIR_TX = 0;
    localparam int DIR_RX = 1;

    // byte offsets inside one channel window
    localparam int OFS_EVENT = 4;
    localparam int OFS_RX_LO = 8;
    localparam int OFS_RX_HI = 12;
    localparam int OFS_TX_LO = 16;
    localparam int OFS_TX_HI = 20;

    // Receive side stamps Delay_Req as master, Sync as slave;
    // transmit side is the mirror image.
    function automatic logic msg_qualifies(input logic is_rx, input logic master,
                                           input logic [1:0] mt);
        logic want_dly;
        want_dly = ~(is_rx ^ master);
        return want_dly ? (mt == MT_DLY_REQ) : (mt == MT_SYNC);
    endfunction

endpackage

// File: rtl/ptp_snap_lock.sv
module ptp_snap_lock
    import ptp_snap_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_i,
    input  logic              ta_i,
    input  logic              clr_i,
    input  logic [TIME_W-1:0] time_i,
    output logic              locked_o,
    output logic [TIME_W-1:0] snap_o
);

    lock_st_t          st_q, st_nxt;
    logic              cap;
    logic [TIME_W-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LK_OPEN;
        else        st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        cap    = 1'b0;
        unique case (st_q)
            LK_OPEN: begin
                if (hit_i) begin
                    cap = 1'b1;
                    if (!ta_i) st_nxt = LK_HELD;      // seize
                end
            end
            LK_HELD: begin
                if (hit_i && (ta_i || clr_i)) begin
                    cap    = 1'b1;                    // reseize / refresh
                    st_nxt = (ta_i && clr_i) ? LK_OPEN : LK_HELD;
                end else if (clr_i) begin
                    st_nxt = LK_OPEN;                 // release
                end
            end
            default: st_nxt = LK_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   snap_q <= '0;
        else if (cap) snap_q <= time_i;
    end

    assign locked_o = (st_q == LK_HELD);
    assign snap_o   = snap_q;

    AST_CAPTURE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_OPEN && hit_i && !ta_i) |=> (locked_o && snap_o == $past(time_i))); // R4
    AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_HELD && !ta_i && !clr_i) |=> $stable(snap_o)); // R5
    AST_CLEAR_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_HELD && clr_i && !hit_i) |=> !locked_o); // R6
    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_HELD && clr_i && hit_i && !ta_i) |=> (locked_o && snap_o == $past(time_i))); // R7
    AST_TA_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LK_OPEN && ta_i) |=> !locked_o); // R8

endmodule

// File: rtl/ptp_snap_chan.sv
module ptp_snap_chan
    import ptp_snap_pkg::*;
#(
    parameter int TIME_W = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tx_evt_i,
    input  logic [1:0]             tx_type_i,
    input  logic                   rx_evt_i,
    input  logic [1:0]             rx_type_i,
    input  logic                   master_i,
    input  logic                   ta_i,
    input  logic [1:0]             clr_i,
    input  logic [TIME_W-1:0]      time_i,
    output logic [1:0]             lock_o,
    output logic [1:0][TIME_W-1:0] snap_o
);

    logic [1:0]      evt_v;
    logic [1:0][1:0] type_v;

    assign evt_v[DIR_TX]  = tx_evt_i;
    assign evt_v[DIR_RX]  = rx_evt_i;
    assign type_v[DIR_TX] = tx_type_i;
    assign type_v[DIR_RX] = rx_type_i;

    for (genvar d = 0; d < 2; d++) begin : g_dir
        logic hit;
        assign hit = evt_v[d] && msg_qualifies(d == DIR_RX, master_i, type_v[d]);

        ptp_snap_lock #(.TIME_W(TIME_W)) u_lock (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit_i   (hit),
            .ta_i    (ta_i),
            .clr_i   (clr_i[d]),
            .time_i  (time_i),
            .locked_o(lock_o[d]),
            .snap_o  (snap_o[d])
        );
    end

endmodule

// File: rtl/ptp_snap_regif.sv
module ptp_snap_regif
    import ptp_snap_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int CH_BASE   = 'h40,
    parameter int CH_STRIDE = 'h20,
    localparam int TIME_W   = 2 * DATA_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                   wr_data,
    input  logic [NUM_CH-1:0][1:0]              lock_i,
    input  logic [NUM_CH-1:0][1:0][TIME_W-1:0]  snap_i,
    output logic [NUM_CH-1:0][1:0]              clr_o,
    output logic [DATA_W-1:0]                   rd_data
);

    logic [NUM_CH-1:0]                 evt_hit;
    logic [NUM_CH-1:0][DATA_W-1:0]     ch_rd;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int BASE = CH_BASE + c * CH_STRIDE;

        assign evt_hit[c]       = (addr == ADDR_W'(BASE + OFS_EVENT));
        assign clr_o[c][DIR_TX] = wr_en && evt_hit[c] && wr_data[DIR_TX];
        assign clr_o[c][DIR_RX] = wr_en && evt_hit[c] && wr_data[DIR_RX];

        always_comb begin
            ch_rd[c] = '0;
            if (evt_hit[c])
                ch_rd[c] = {{(DATA_W-2){1'b0}}, lock_i[c]};
            else if (addr == ADDR_W'(BASE + OFS_RX_LO))
                ch_rd[c] = snap_i[c][DIR_RX][DATA_W-1:0];
            else if (addr == ADDR_W'(BASE + OFS_RX_HI))
                ch_rd[c] = snap_i[c][DIR_RX][TIME_W-1:DATA_W];
            else if (addr == ADDR_W'(BASE + OFS_TX_LO))
                ch_rd[c] = snap_i[c][DIR_TX][DATA_W-1:0];
            else if (addr == ADDR_W'(BASE + OFS_TX_HI))
                ch_rd[c] = snap_i[c][DIR_TX][TIME_W-1:DATA_W];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CH; c++) rd_data |= ch_rd[c];
    end

    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt_hit)); // R9
    AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |-> (clr_o == '0)); // R10

endmodule

// File: rtl/ptp_snap_latch.sv
module ptp_snap_latch
    import ptp_snap_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    localparam int TIME_W = 2 * DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TIME_W-1:0]     sys_time,
    input  logic [NUM_CH-1:0]     tx_evt,
    input  logic [2*NUM_CH-1:0]   tx_type,
    input  logic [NUM_CH-1:0]     rx_evt,
    input  logic [2*NUM_CH-1:0]   rx_type,
    input  logic [NUM_CH-1:0]     mode_master,
    input  logic [NUM_CH-1:0]     ts_all,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wr_data,
    output logic [DATA_W-1:0]     rd_data
);

    logic [NUM_CH-1:0][1:0]             lock_w;
    logic [NUM_CH-1:0][1:0]             clr_w;
    logic [NUM_CH-1:0][1:0][TIME_W-1:0] snap_w;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        ptp_snap_chan #(.TIME_W(TIME_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tx_evt_i (tx_evt[c]),
            .tx_type_i(tx_type[2*c +: 2]),
            .rx_evt_i (rx_evt[c]),
            .rx_type_i(rx_type[2*c +: 2]),
            .master_i (mode_master[c]),
            .ta_i     (ts_all[c]),
            .clr_i    (clr_w[c]),
            .time_i   (sys_time),
            .lock_o   (lock_w[c]),
            .snap_o   (snap_w[c])
        );
    end

    ptp_snap_regif #(
        .NUM_CH(NUM_CH),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regif (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wr_data(wr_data),
        .lock_i (lock_w),
        .snap_i (snap_w),
        .clr_o  (clr_w),
        .rd_data(rd_data)
    );

endmodule

// File: tb/sim_ptp_snap_latch.sv
module sim_ptp_snap_latch;

    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_time = '0;
    logic [2:0]  tx_evt = '0, rx_evt = '0, mode_master = '0, ts_all = '0;
    logic [5:0]  tx_type = '0, rx_type = '0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int checks = 0, fails = 0;
    bit done = 0;

    logic        m_lock [NCH][2];
    logic [63:0] m_snap [NCH][2];

    always #5 clk = ~clk;

    ptp_snap_latch u0 (
        .clk(clk), .rst_n(rst_n), .sys_time(sys_time),
        .tx_evt(tx_evt), .tx_type(tx_type), .rx_evt(rx_evt), .rx_type(rx_type),
        .mode_master(mode_master), .ts_all(ts_all),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
    );

    // rx: master stamps Delay_Req(1), slave stamps Sync(0); tx mirrored
    function automatic bit qual(input bit is_rx, input bit master, input logic [1:0] mt);
        if (is_rx) return master ? (mt == 2'd1) : (mt == 2'd0);
        return master ? (mt == 2'd0) : (mt == 2'd1);
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        for (int c = 0; c < NCH; c++) begin
            int b = 'h40 + c * 'h20;
            if (a == b + 4)  return {30'd0, m_lock[c][1], m_lock[c][0]};
            if (a == b + 8)  return m_snap[c][1][31:0];
            if (a == b + 12) return m_snap[c][1][63:32];
            if (a == b + 16) return m_snap[c][0][31:0];
            if (a == b + 20) return m_snap[c][0][63:32];
        end
        return 32'd0;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NCH; c++)
            for (int d = 0; d < 2; d++) begin
                m_lock[c][d] = 1'b0;
                m_snap[c][d] = '0;
            end
    endtask

    // apply the requirements to the stimulus about to be clocked in
    task automatic model_step();
        for (int c = 0; c < NCH; c++)
            for (int d = 0; d < 2; d++) begin
                bit ev  = (d == 1) ? rx_evt[c] : tx_evt[c];
                logic [1:0] mt = (d == 1) ? rx_type[2*c +: 2] : tx_type[2*c +: 2];
                bit hit = ev && qual(d == 1, mode_master[c], mt);
                bit clr = wr_en && (addr == 12'('h44 + c * 'h20)) && wr_data[d];
                if (hit && (!m_lock[c][d] || ts_all[c] || clr)) begin
                    m_snap[c][d] = sys_time;
                    m_lock[c][d] = ts_all[c] ? (m_lock[c][d] && !clr) : 1'b1;
                end else if (clr) begin
                    m_lock[c][d] = 1'b0;
                end
            end
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
        tx_evt = '0; rx_evt = '0; wr_en = 1'b0;
        sys_time = {$urandom, $urandom};
    endtask

    task automatic rd(input logic [11:0] a, input string req);
        logic [31:0] e;
        addr = a;
        #1;
        e = exp_read(a);
        checks++;
        if (rd_data !== e) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rd_data, e);
        end
    endtask

    task automatic sweep(input string req);
        for (int c = 0; c < NCH; c++)
            for (int o = 4; o <= 20; o += 4) rd(12'('h40 + c * 'h20 + o), req);
    endtask

    task automatic set_ev(input int c, input bit is_rx, input logic [1:0] mt);
        if (is_rx) begin rx_evt[c] = 1'b1; rx_type[2*c +: 2] = mt; end
        else       begin tx_evt[c] = 1'b1; tx_type[2*c +: 2] = mt; end
    endtask

    task automatic set_wr(input int c, input logic [31:0] d);
        wr_en = 1'b1; addr = 12'('h44 + c * 'h20); wr_data = d;
    endtask

    task automatic expect_val(input logic [11:0] a, input logic [31:0] e, input string req);
        addr = a;
        #1;
        checks++;
        if (rd_data !== e) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rd_data, e);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state; R9 unmapped addresses
        sweep("R1");
        rd(12'h000, "R9"); rd(12'h0A4, "R9"); rd(12'h046, "R9");

        // R2 receive qualification, ch0 master
        mode_master = 3'b001;
        set_ev(0, 1, 2'd0); tick(); expect_val(12'h044, 32'd0, "R2");
        set_ev(0, 1, 2'd2); tick(); expect_val(12'h044, 32'd0, "R2");
        set_ev(0, 1, 2'd1); tick(); expect_val(12'h044, 32'd2, "R2");
        rd(12'h048, "R4"); rd(12'h04C, "R4");
        // R5 held: another qualifying receive must not move the snapshot
        set_ev(0, 1, 2'd1); tick(); rd(12'h048, "R5"); rd(12'h04C, "R5");
        // R3 transmit qualification, ch1 slave
        set_ev(1, 0, 2'd0); tick(); expect_val(12'h064, 32'd0, "R3");
        set_ev(1, 0, 2'd3); tick(); expect_val(12'h064, 32'd0, "R3");
        set_ev(1, 0, 2'd1); tick(); expect_val(12'h064, 32'd1, "R3");
        rd(12'h070, "R4"); rd(12'h074, "R4");
        // R2 slave receive of Sync on ch1
        set_ev(1, 1, 2'd0); tick(); expect_val(12'h064, 32'd3, "R2");
        // R11 other channels untouched
        sweep("R11");
        // R6 write 0 has no effect; R9 reserved bits ignore writes
        set_wr(1, 32'h0); tick(); expect_val(12'h064, 32'd3, "R6");
        set_wr(1, 32'hFFFF_FFFC); tick(); expect_val(12'h064, 32'd3, "R9");
        set_wr(1, 32'h2); tick(); expect_val(12'h064, 32'd1, "R6");
        // R10 repeated reads do not clear
        expect_val(12'h064, 32'd1, "R10"); rd(12'h070, "R10"); expect_val(12'h064, 32'd1, "R10");
        // R7 clear and capture together on ch0 receive
        set_wr(0, 32'h2); set_ev(0, 1, 2'd1); tick();
        expect_val(12'h044, 32'd2, "R7"); rd(12'h048, "R7"); rd(12'h04C, "R7");
        // R8 timestamp-all on ch2 (slave): tx Delay_Req overwrites, no flag
        ts_all = 3'b100;
        set_ev(2, 0, 2'd1); tick(); expect_val(12'h084, 32'd0, "R8"); rd(12'h090, "R8");
        set_ev(2, 0, 2'd1); tick(); rd(12'h090, "R8"); rd(12'h094, "R8");
        ts_all = 3'b000;
        sweep("R11");

        // random mix on all channels
        for (int i = 0; i < 3000; i++) begin
            mode_master = 3'($urandom);
            ts_all      = (($urandom % 8) == 0) ? 3'($urandom) : 3'b000;
            tx_evt = 3'($urandom); rx_evt = 3'($urandom);
            tx_type = 6'($urandom); rx_type = 6'($urandom);
            if (($urandom % 4) == 0) set_wr($urandom % NCH, $urandom);
            tick();
            rd(12'('h40 + ($urandom % 4) * 'h20 + ($urandom % 6) * 4), "R11");
        end
        sweep("R5");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule